// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This block rewrites physical byte addresses for tiled surfaces on memory that is split across two interleaved channels. Channels alternate on every 64-byte block, so address bit 6 chooses the channel. Tiled walks move in both directions, so the engine that reads tiled data folds further address bits into bit 6. A producer that writes the same surface must apply the same fold. The block takes a stream of addresses, each tagged with a tiling kind. It returns each address with bit 6 replaced by the XOR of bit 6 and a selected set of higher bits. All other bits pass through unchanged.

A small selector turns the memory configuration into one swizzle mode for X-tiled requests and one for Y-tiled requests. One board family supplies a controller configuration word. It decodes the addressing mode and two randomization flags. The other family supplies two rank-boundary values, one per channel, and only tests them for equality. Each result carries the tiling that was actually applied and a reported mode. In the reported mode, any bit-17 variant becomes its bit-17-free counterpart.

Top module: `tile_swizzler`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Every output address bit other than bit 6 equals the same bit of the accepted input address.
- R3: Tiling code 0 (linear) and code 3 (reserved) are never swizzled: the address is unchanged, out_tiling is 0 and out_mode is 0.
- R4: With cfg_family=0 and an addressing field cfg_word[1:0] of 0 (single channel), 1 (asymmetric dual) or 3 (reserved), X (tiling 1) and Y (tiling 2) requests both get mode none and keep their address.
- R5: With cfg_family=0, cfg_word[1:0]=2 (interleaved) and cfg_word[10]=1 (randomization off), X requests get bit6^=a9^a10 and Y requests get bit6^=a9.
- R6: With interleaved mode and cfg_word[10]=0: if cfg_word[9]=0, X gets bit6^=a9^a10^a11 and Y gets bit6^=a9^a11. If cfg_word[9]=1, X gets bit6^=a9^a10^a17 and Y gets bit6^=a9^a17.
- R7: With cfg_family=0, a cfg_word of all ones makes both modes unknown. A tiled request is then returned as linear: address unchanged, out_tiling 0, out_mode 0.
- R8: With cfg_family=1, rank_a equal to rank_b gives X bit6^=a9^a10 and Y bit6^=a9. Unequal values give no swizzle.
- R9: out_mode codes are 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11. The bit-17 modes are reported as 1 (Y) or 2 (X), and codes 5 to 7 never appear.
- R10: An accepted request appears at the output one clock after acceptance. in_ready is !out_valid or out_ready, and while out_valid is high with out_ready low, all outputs hold.
- R11: A configuration change takes effect for requests accepted from the second clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_family | input | 1 | 0: decode cfg_word; 1: compare rank values |
| cfg_word | input | CFG_W | Memory controller configuration word |
| rank_a | input | RANK_W | Rank boundary of channel A |
| rank_b | input | RANK_W | Rank boundary of channel B |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | ADDR_W | Physical byte address |
| in_tiling | input | 2 | 0 linear, 1 X, 2 Y, 3 reserved |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready |
| out_addr | output | ADDR_W | Swizzled address |
| out_tiling | output | 2 | Tiling actually applied |
| out_mode | output | 3 | Reported swizzle mode |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit configuration word and 16-bit rank values. The 32-bit address includes bit 17, so the bit-17 variants are applied in full. The bench can then see them folded in the report while the address still carries the bit-17 term. The 32-bit configuration word makes the all-ones case distinct from the reserved addressing code that shares its low bits. Random backpressure on out_ready, together with address patterns that toggle bits 6, 9, 10, 11 and 17 independently, brings both the hold behaviour and every XOR term within reach.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNK      = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef struct packed {
    logic b17;
    logic b11;
    logic b10;
    logic b9;
  } swz_sel_t;

  // Which higher address bits feed the bit-6 XOR for a given mode.
  function automatic swz_sel_t sel_of(swz_mode_e m);
    swz_sel_t s;
    s = '0;
    unique case (m)
      SWZ_9:       s.b9 = 1'b1;
      SWZ_9_10:    begin s.b9 = 1'b1; s.b10 = 1'b1; end
      SWZ_9_11:    begin s.b9 = 1'b1; s.b11 = 1'b1; end
      SWZ_9_10_11: begin s.b9 = 1'b1; s.b10 = 1'b1; s.b11 = 1'b1; end
      SWZ_9_17:    begin s.b9 = 1'b1; s.b17 = 1'b1; end
      SWZ_9_10_17: begin s.b9 = 1'b1; s.b10 = 1'b1; s.b17 = 1'b1; end
      default:     s = '0;
    endcase
    return s;
  endfunction

  // Mode as presented to the consumer: bit-17 terms hidden.
  function automatic swz_mode_e report_of(swz_mode_e m);
    swz_mode_e r;
    unique case (m)
      SWZ_9_17:    r = SWZ_9;
      SWZ_9_10_17: r = SWZ_9_10;
      SWZ_UNK:     r = SWZ_NONE;
      default:     r = m;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/swz_mode_select.sv
module swz_mode_select
  import swz_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int RANK_W    = 16,
  parameter int AMODE_LSB = 0,
  parameter int XDIS_BIT  = 10,
  parameter int B17_BIT   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_family,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [RANK_W-1:0] rank_a,
  input  logic [RANK_W-1:0] rank_b,
  output swz_mode_e         mode_x,
  output swz_mode_e         mode_y
);

  localparam logic [CFG_W-1:0] ALL_ONES  = '1;
  localparam logic [1:0]       AM_INTLV  = 2'd2;

  logic [1:0] amode;
  swz_mode_e  nx_x, nx_y;

  assign amode = cfg_word[AMODE_LSB +: 2];

  always_comb begin
    nx_x = SWZ_NONE;
    nx_y = SWZ_NONE;
    if (cfg_family) begin
      if (rank_a == rank_b) begin
        nx_x = SWZ_9_10;
        nx_y = SWZ_9;
      end
    end else if (cfg_word == ALL_ONES) begin
      nx_x = SWZ_UNK;
      nx_y = SWZ_UNK;
    end else if (amode == AM_INTLV) begin
      if (cfg_word[XDIS_BIT]) begin
        nx_x = SWZ_9_10;
        nx_y = SWZ_9;
      end else if (!cfg_word[B17_BIT]) begin
        nx_x = SWZ_9_10_11;
        nx_y = SWZ_9_11;
      end else begin
        nx_x = SWZ_9_10_17;
        nx_y = SWZ_9_17;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_x <= SWZ_UNK;
      mode_y <= SWZ_UNK;
    end else begin
      mode_x <= nx_x;
      mode_y <= nx_y;
    end
  end

endmodule

// File: rtl/swz_xor_core.sv
module swz_xor_core
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SWZ_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_sel_t          sel_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam bit HAS_B17 = (ADDR_W > 17);

  logic b17_v;
  logic flip;

  generate
    if (HAS_B17) begin : g_b17
      assign b17_v = addr_i[17];
    end else begin : g_no_b17
      assign b17_v = 1'b0;
    end
  endgenerate

  assign flip = (sel_i.b9  & addr_i[9])  ^
                (sel_i.b10 & addr_i[10]) ^
                (sel_i.b11 & addr_i[11]) ^
                (sel_i.b17 & b17_v);

  generate
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
      if (g == SWZ_BIT) begin : g_swz
        assign addr_o[g] = addr_i[g] ^ flip;
      end else begin : g_pass
        assign addr_o[g] = addr_i[g];
      end
    end
  endgenerate

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (in_ready) begin
      v_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      d_q <= in_data;
    end
  end

endmodule

// File: rtl/tile_swizzler.sv
module tile_swizzler
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int RANK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_family,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [RANK_W-1:0] rank_a,
  input  logic [RANK_W-1:0] rank_b,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tiling,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_tiling,
  output logic [2:0]        out_mode
);

  localparam int PKT_W = ADDR_W + 2 + 3;

  swz_mode_e         mode_x, mode_y;
  swz_mode_e         picked, applied, reported;
  tile_e             req_tile, eff_tile;
  swz_sel_t          sel;
  logic [ADDR_W-1:0] swz_addr;
  logic [PKT_W-1:0]  pkt_in, pkt_out;

  swz_mode_select #(
    .CFG_W  (CFG_W),
    .RANK_W (RANK_W)
  ) u_sel (
    .clk        (clk),
    .rst        (rst),
    .cfg_family (cfg_family),
    .cfg_word   (cfg_word),
    .rank_a     (rank_a),
    .rank_b     (rank_b),
    .mode_x     (mode_x),
    .mode_y     (mode_y)
  );

  always_comb begin
    req_tile = tile_e'(in_tiling);
    unique case (req_tile)
      TILE_X:  picked = mode_x;
      TILE_Y:  picked = mode_y;
      default: picked = SWZ_NONE;
    endcase
    if (picked == SWZ_UNK) begin
      applied  = SWZ_NONE;
      eff_tile = TILE_LIN;
    end else begin
      applied  = picked;
      eff_tile = (req_tile == TILE_X || req_tile == TILE_Y) ? req_tile : TILE_LIN;
    end
    sel      = sel_of(applied);
    reported = report_of(applied);
  end

  swz_xor_core #(
    .ADDR_W (ADDR_W)
  ) u_xor (
    .addr_i (in_addr),
    .sel_i  (sel),
    .addr_o (swz_addr)
  );

  assign pkt_in = {eff_tile, reported, swz_addr};

  swz_out_stage #(
    .W (PKT_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pkt_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pkt_out)
  );

  assign out_addr   = pkt_out[ADDR_W-1:0];
  assign out_mode   = pkt_out[ADDR_W +: 3];
  assign out_tiling = pkt_out[ADDR_W+3 +: 2];

endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_tiling,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_tiling,
  input logic [2:0]        out_mode
);

  localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << 6);

  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_mode) && $stable(out_tiling)));

  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ((out_addr & KEEP) == ($past(in_addr) & KEEP)));

  a_r3_linear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_tiling == 2'd0 || in_tiling == 2'd3)) |=>
      (out_addr == $past(in_addr) && out_mode == 3'd0 && out_tiling == 2'd0));

  a_r9_report_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mode <= 3'd4));

  a_r7_linear_plain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tiling == 2'd0) |-> (out_mode == 3'd0));

endmodule

bind tile_swizzler swz_checker #(.ADDR_W(ADDR_W)) u_swz_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_addr    (in_addr),
  .in_tiling  (in_tiling),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_tiling (out_tiling),
  .out_mode   (out_mode)
);

// File: tb/tile_swizzler_bench.sv
module tile_swizzler_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_family = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic [15:0] rank_a = 16'h0, rank_b = 16'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = 32'h0;
  logic [1:0]  in_tiling = 2'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [1:0]  out_tiling;
  logic [2:0]  out_mode;

  int errors = 0;
  int checks = 0;
  int pcount = 0;
  bit bp_on  = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] a;
    logic [1:0]  t;
    logic [2:0]  m;
    int          pc;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) pcount <= pcount + 1;

  tile_swizzler u_tile_swizzler (
    .clk        (clk),
    .rst        (rst),
    .cfg_family (cfg_family),
    .cfg_word   (cfg_word),
    .rank_a     (rank_a),
    .rank_b     (rank_b),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_addr    (in_addr),
    .in_tiling  (in_tiling),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_tiling (out_tiling),
    .out_mode   (out_mode)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bench-side mode model: 0 none,1 b9,2 b9+10,3 b9+11,4 b9+10+11,5 b9+17,6 b9+10+17,7 unknown
  function automatic logic [2:0] model_mode(input logic [1:0] t);
    logic [2:0] mx, my;
    mx = 3'd0; my = 3'd0;
    if (cfg_family) begin
      if (rank_a == rank_b) begin mx = 3'd2; my = 3'd1; end
    end else if (cfg_word == 32'hFFFF_FFFF) begin
      mx = 3'd7; my = 3'd7;
    end else if (cfg_word[1:0] == 2'd2) begin
      if (cfg_word[10])     begin mx = 3'd2; my = 3'd1; end
      else if (!cfg_word[9]) begin mx = 3'd4; my = 3'd3; end
      else                  begin mx = 3'd6; my = 3'd5; end
    end
    if (t == 2'd1) return mx;
    if (t == 2'd2) return my;
    return 3'd0;
  endfunction

  task automatic set_cfg(input logic fam, input logic [31:0] w,
                         input logic [15:0] ra, input logic [15:0] rb);
    @(posedge clk); #1;
    cfg_family = fam; cfg_word = w; rank_a = ra; rank_b = rb;
    repeat (2) @(posedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] t, input string tag);
    exp_t e;
    logic [2:0] m;
    logic f;
    m = model_mode(t);
    e.a = a; e.tag = tag;
    if (m == 3'd7 || t == 2'd0 || t == 2'd3) begin
      e.t = 2'd0; e.m = 3'd0;
    end else begin
      f = 1'b0;
      case (m)
        3'd1: f = a[9];
        3'd2: f = a[9] ^ a[10];
        3'd3: f = a[9] ^ a[11];
        3'd4: f = a[9] ^ a[10] ^ a[11];
        3'd5: f = a[9] ^ a[17];
        3'd6: f = a[9] ^ a[10] ^ a[17];
        default: f = 1'b0;
      endcase
      e.a[6] = a[6] ^ f;
      e.t = t;
      e.m = (m == 3'd5) ? 3'd1 : (m == 3'd6) ? 3'd2 : m;
    end
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = a; in_tiling = t;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    e.pc = pcount;
    q.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  bit          hold_prev = 1'b0;
  logic [31:0] h_a;
  logic [1:0]  h_t;
  logic [2:0]  h_m;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev)
        check(out_valid && out_addr == h_a && out_tiling == h_t && out_mode == h_m,
              "R10", "hold under backpressure", out_addr, h_a);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected output", out_addr, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_addr == e.a, e.tag, "address", out_addr, e.a);
          check(out_tiling == e.t, e.tag, "tiling", {30'h0, out_tiling}, {30'h0, e.t});
          check(out_mode == e.m, e.tag, "mode", {29'h0, out_mode}, {29'h0, e.m});
          if (!bp_on)
            check(pcount == e.pc + 1, "R10", "latency", pcount, e.pc + 1);
        end
      end
      hold_prev = out_valid && !out_ready;
      h_a = out_addr; h_t = out_tiling; h_m = out_mode;
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);

    // R6 bit-11 variant, with linear and reserved requests (R3)
    set_cfg(1'b0, 32'h0000_0002, 16'h0, 16'h0);
    send(32'h0000_0E40, 2'd0, "R3");
    send(32'h0000_0E40, 2'd3, "R3");
    send(32'h0000_0E40, 2'd1, "R6");
    send(32'h0000_0A00, 2'd1, "R6");
    send(32'h0000_0800, 2'd2, "R6");
    send(32'hDEAD_BEEF, 2'd2, "R2");
    // R6 bit-17 variant (reported folded, R9)
    set_cfg(1'b0, 32'h0000_0202, 16'h0, 16'h0);
    send(32'h0002_0000, 2'd1, "R9");
    send(32'h0002_0000, 2'd2, "R9");
    send(32'h0002_0600, 2'd1, "R6");
    send(32'h0002_0840, 2'd2, "R6");
    // R5 randomization disabled
    set_cfg(1'b0, 32'h0000_0402, 16'h0, 16'h0);
    send(32'h0000_0C00, 2'd1, "R5");
    send(32'h0000_0A40, 2'd2, "R5");
    send(32'h0002_0800, 2'd1, "R5");
    // R4 non-interleaved addressing codes
    set_cfg(1'b0, 32'h0000_0000, 16'h0, 16'h0);
    send(32'h0000_0E00, 2'd1, "R4");
    set_cfg(1'b0, 32'h0000_0001, 16'h0, 16'h0);
    send(32'h0000_0E00, 2'd2, "R4");
    set_cfg(1'b0, 32'h0000_0003, 16'h0, 16'h0);
    send(32'h0000_0200, 2'd1, "R4");
    // R7 all ones
    set_cfg(1'b0, 32'hFFFF_FFFF, 16'h0, 16'h0);
    send(32'h0002_0E40, 2'd1, "R7");
    send(32'h0000_0200, 2'd2, "R7");
    // R8 rank family
    set_cfg(1'b1, 32'hFFFF_FFFF, 16'h0400, 16'h0400);
    send(32'h0000_0600, 2'd1, "R8");
    send(32'h0000_0600, 2'd2, "R8");
    set_cfg(1'b1, 32'h0000_0002, 16'h0400, 16'h0200);
    send(32'h0000_0600, 2'd1, "R8");
    // R11: first request right after a config change uses the new mode
    @(posedge clk); #1;
    cfg_family = 1'b0; cfg_word = 32'h0000_0402;
    @(posedge clk);
    send(32'h0000_0200, 2'd1, "R11");
    // R10 random traffic under backpressure
    bp_on = 1'b1;
    set_cfg(1'b0, 32'h0000_0202, 16'h0, 16'h0);
    for (int i = 0; i < 60; i++) send($urandom, 2'($urandom % 4), "R10");
    set_cfg(1'b0, 32'h0000_0002, 16'h0, 16'h0);
    for (int i = 0; i < 40; i++) send($urandom, 2'($urandom % 4), "R10");
    set_cfg(1'b1, 32'h0, 16'h0033, 16'h0033);
    for (int i = 0; i < 40; i++) send($urandom, 2'($urandom % 4), "R10");
    for (int i = 0; i < 200 && q.size() != 0; i++) @(posedge clk);
    bp_on = 1'b0;
    repeat (3) @(posedge clk);
    check(q.size() == 0, "R10", "queue drained", q.size(), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule